// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that advances on an instruction-rate enable pulse. The pulse first passes through a selectable prescaler with ratios 1, 4 or 16. Each prescaler output moves the count forward by one. When the count equals a programmable period value, the next advance loads zero instead of count+1, and a one-cycle match pulse goes out to neighbouring logic. Every such match steps a postscaler with a ratio of 1 to 16. Each time the postscaler completes a round, it sets a sticky interrupt flag.

Software reaches the block through a plain single-cycle register port. The port has a 2-bit address, a write strobe, write data and combinational read data. Through it software can read and write the count, the period and a control word, and can clear the flag. The block moves no data streams, so it has no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal.

Register map (bus_addr): 0 = count, 1 = period, 2 = control, 3 = flag (bit 0).
Control word layout: bit 0 = run; bits 2:1 = prescale select; bits 6:3 = postscale select; bit 7 reads 0.

Top module: `tpt_top`

## Requirements
- R1: After reset, the count reads 00h, the period reads FFh, the control word reads 00h, the flag reads 0 and match_pulse is 0.
- R2: Prescale select (control bits 2:1) gives one count advance per 1 enabled tick for value 0, per 4 for value 1, and per 16 for values 2 and 3.
- R3: Each advance adds one to the count. When the count equals the current period, the advance loads 00h instead. A period written below the current count lets the count run on to FFh and wrap to 00h without a match.
- R4: match_pulse is high for exactly the one cycle in which the count first shows 00h after a period-match reload. A plain FFh-to-00h wrap does not raise it.
- R5: With postscale select n (control bits 6:3), the flag is set on every (n+1)th period match.
- R6: The flag stays set until a write to address 3 loads bit 0 with 0. A hardware set in the same cycle as such a write wins.
- R7: A write to address 0 loads the count and clears the prescale and postscale counters. It takes precedence over an advance in the same cycle.
- R8: A write to address 2 loads the control word and clears the prescale and postscale counters. The count keeps its value.
- R9: While run (control bit 0) is 0, tick_en is ignored and the count and prescaler hold.
- R10: The count and the period read back the last value written to them through their addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Instruction-rate enable feeding the prescaler |
| bus_addr | input | 2 | Register select: 0 count, 1 period, 2 control, 3 flag |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| match_pulse | output | 1 | One-cycle pulse on a period-match reload |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
Two pairs of events can land in the same cycle: a hardware flag set with a software flag clear, and a software write to the count or control word with a prescaler output. The bench sets the period to 0 with a 1:1 prescaler and a 1:1 postscaler, so that every enabled tick sets the flag. It then writes the flag clear while tick_en is high, and expects the flag to remain 1. It also writes the count and the control word part-way through a prescale round, and checks that the next advance comes only after a full new round. A per-cycle reference model judges both pairs, alongside the explicit checks.

// File: rtl/tpt_pkg.sv
package tpt_pkg;
  localparam int unsigned PRE_SEL_W  = 2;
  localparam int unsigned POST_SEL_W = 4;
  localparam int unsigned CTRL_W     = 1 + PRE_SEL_W + POST_SEL_W;

  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_PERIOD = 2'd1,
    REG_CTRL   = 2'd2,
    REG_FLAG   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [POST_SEL_W-1:0] post_sel;
    logic [PRE_SEL_W-1:0]  pre_sel;
    logic                  run;
  } ctrl_t;
endpackage

// File: rtl/tpt_prescaler.sv
module tpt_prescaler #(
  parameter int unsigned PRE_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       step,
  input  logic [1:0] sel,
  output logic       fire
);
  localparam logic [PRE_W-1:0] LIM_QUARTER = PRE_W'(3);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim;

  always_comb begin
    case (sel)
      2'd0:    lim = '0;
      2'd1:    lim = LIM_QUARTER;
      default: lim = '1;
    endcase
  end

  assign fire = step & ~clr & (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (step)   cnt_q <= fire ? '0 : cnt_q + PRE_W'(1);
  end
endmodule

// File: rtl/tpt_counter.sv
module tpt_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         hit,
  output logic         pulse
);
  logic [W-1:0] cnt_q;

  assign hit = adv & ~load & (cnt_q == period);
  assign cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (adv)   cnt_q <= hit ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= hit;
  end
endmodule

// File: rtl/tpt_postscaler.sv
module tpt_postscaler #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ev,
  input  logic [W-1:0] sel,
  output logic         set
);
  logic [W-1:0] cnt_q;

  assign set = ev & ~clr & (cnt_q == sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (ev)   cnt_q <= set ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/tpt_top.sv
module tpt_top
  import tpt_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             match_pulse,
  output logic             irq_flag
);
  localparam logic [CNT_W-1:0] PERIOD_RST = '1;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             wr_count, wr_period, wr_ctrl, wr_flag;
  logic             scaler_clr;
  logic             run_en;
  logic             pre_fire;
  logic             period_hit;
  logic             post_set;

  assign wr_count   = bus_we & (bus_addr == REG_COUNT);
  assign wr_period  = bus_we & (bus_addr == REG_PERIOD);
  assign wr_ctrl    = bus_we & (bus_addr == REG_CTRL);
  assign wr_flag    = bus_we & (bus_addr == REG_FLAG);
  assign scaler_clr = wr_count | wr_ctrl;
  assign run_en     = ctrl_q.run;

  tpt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (scaler_clr),
    .step  (run_en & tick_en),
    .sel   (ctrl_q.pre_sel),
    .fire  (pre_fire)
  );

  tpt_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (pre_fire),
    .load     (wr_count),
    .load_val (bus_wdata),
    .period   (period_q),
    .cnt      (cnt_q),
    .hit      (period_hit),
    .pulse    (match_pulse)
  );

  tpt_postscaler #(.W(POST_SEL_W)) u_post (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (scaler_clr),
    .ev    (period_hit),
    .sel   (ctrl_q.post_sel),
    .set   (post_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= PERIOD_RST;
      ctrl_q   <= '0;
    end else begin
      if (wr_period) period_q <= bus_wdata;
      if (wr_ctrl)   ctrl_q   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (post_set) flag_q <= 1'b1;
    else if (wr_flag)  flag_q <= bus_wdata[0];
  end

  assign irq_flag = flag_q;

  always_comb begin
    case (bus_addr)
      REG_COUNT:  bus_rdata = cnt_q;
      REG_PERIOD: bus_rdata = period_q;
      REG_CTRL:   bus_rdata = CNT_W'(ctrl_q);
      default:    bus_rdata = CNT_W'(flag_q);
    endcase
  end
endmodule

// File: rtl/tpt_checker.sv
module tpt_checker
  import tpt_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic [CNT_W-1:0] count_q,
  input logic             run,
  input logic             post_set,
  input logic             match_pulse,
  input logic             irq_flag
);
  logic wr_c, wr_k, wr_f;
  assign wr_c = bus_we && bus_addr == REG_COUNT;
  assign wr_k = bus_we && bus_addr == REG_CTRL;
  assign wr_f = bus_we && bus_addr == REG_FLAG;

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_c |=> (count_q == $past(count_q) || count_q == $past(count_q) + CNT_W'(1) || count_q == '0));

  p_pulse_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> count_q == '0);

  p_set_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    post_set |=> irq_flag);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !(wr_f && !bus_wdata[0])) |=> irq_flag);

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c |=> count_q == $past(bus_wdata));

  p_ctrl_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_k |=> $stable(count_q));

  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_c) |=> $stable(count_q));
endmodule

bind tpt_top tpt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .count_q     (cnt_q),
  .run         (run_en),
  .post_set    (post_set),
  .match_pulse (match_pulse),
  .irq_flag    (irq_flag)
);

// File: tb/sim_tpt_top.sv
module sim_tpt_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       match_pulse;
  logic       irq_flag;

  always #5 clk = ~clk;

  tpt_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .match_pulse(match_pulse), .irq_flag(irq_flag)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_per, m_ctrl, m_pre, m_post, m_flag, m_pulse;

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_cnt;
      1: return m_per;
      2: return m_ctrl;
      default: return m_flag;
    endcase
  endfunction

  always @(posedge clk) begin
    int ratio;
    int nsel;
    int hit;
    int hw;
    if (!rst_n) begin
      m_cnt = 0; m_per = 255; m_ctrl = 0; m_pre = 0; m_post = 0; m_flag = 0; m_pulse = 0;
    end else begin
      ratio = ((m_ctrl >> 1) & 3) == 0 ? 1 : (((m_ctrl >> 1) & 3) == 1 ? 4 : 16);
      nsel  = (m_ctrl >> 3) & 15;
      hit = 0; hw = 0;
      if (bus_we && (bus_addr == 2'd0 || bus_addr == 2'd2)) begin
        m_pre = 0; m_post = 0;
        if (bus_addr == 2'd0) m_cnt = int'(bus_wdata);
        else                  m_ctrl = int'(bus_wdata) & 127;
      end else if ((m_ctrl & 1) != 0 && tick_en) begin
        m_pre++;
        if (m_pre == ratio) begin
          m_pre = 0;
          if (m_cnt == m_per) begin
            m_cnt = 0; hit = 1; m_post++;
            if (m_post == nsel + 1) begin m_post = 0; hw = 1; end
          end else begin
            m_cnt = (m_cnt + 1) % 256;
          end
        end
      end
      if (bus_we && bus_addr == 2'd1) m_per = int'(bus_wdata);
      if (hw) m_flag = 1;
      else if (bus_we && bus_addr == 2'd3) m_flag = int'(bus_wdata[0]);
      m_pulse = hit;
    end
    #2;
    if (rst_n && !done) begin
      chk("R3 R10 model read", int'(bus_rdata), exp_rd(int'(bus_addr)));
      chk("R4 model pulse", int'(match_pulse), m_pulse);
      chk("R5 R6 model flag", int'(irq_flag), m_flag);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); bus_we = 1'b1; bus_addr = 2'(a); bus_wdata = 8'(d); tick_en = 1'b0;
    @(negedge clk); bus_we = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); bus_we = 1'b0; bus_addr = 2'(a); tick_en = 1'b0;
    #1 v = int'(bus_rdata);
  endtask

  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk); bus_we = 1'b0; bus_addr = 2'd0; tick_en = 1'b1;
    end
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, v); chk("R1 count", v, 8'h00);
    rd(1, v); chk("R1 period", v, 8'hFF);
    rd(2, v); chk("R1 control", v, 8'h00);
    rd(3, v); chk("R1 flag", v, 0);
    chk("R1 pulse", int'(match_pulse), 0);
    // R10 readback
    wr(1, 8'h5A); rd(1, v); chk("R10 period readback", v, 8'h5A);
    wr(0, 8'h33); rd(0, v); chk("R10 R7 count readback", v, 8'h33);
    wr(1, 8'hFF);
    // R9 disabled: ticks ignored
    run(10); rd(0, v); chk("R9 frozen count", v, 8'h33);
    // R2 prescale ratios
    wr(2, 8'h03); wr(0, 0);
    run(8); rd(0, v); chk("R2 ratio4 8 ticks", v, 2);
    run(3); rd(0, v); chk("R2 ratio4 partial", v, 2);
    run(1); rd(0, v); chk("R2 ratio4 complete", v, 3);
    wr(2, 8'h05); wr(0, 0);
    run(32); rd(0, v); chk("R2 ratio16 sel2", v, 2);
    wr(2, 8'h07); wr(0, 0);
    run(16); rd(0, v); chk("R2 ratio16 sel3", v, 1);
    wr(2, 8'h01); wr(0, 0);
    run(5); rd(0, v); chk("R2 ratio1", v, 5);
    // R8 control write keeps count, clears prescaler
    wr(2, 8'h03); run(2);
    wr(2, 8'h03); rd(0, v); chk("R8 count kept", v, 5);
    run(3); rd(0, v); chk("R8 prescaler cleared", v, 5);
    run(1); rd(0, v); chk("R8 advance after full round", v, 6);
    // R7 count write clears prescaler
    run(2); wr(0, 8'h40);
    run(3); rd(0, v); chk("R7 prescaler cleared", v, 8'h40);
    run(1); rd(0, v); chk("R7 advance", v, 8'h41);
    // R3 R5 postscale 1:3 with period 3
    wr(3, 0); wr(1, 3); wr(2, 8'h11); wr(0, 0);
    run(4); rd(0, v); chk("R3 reload to zero", v, 0);
    run(4); rd(3, v); chk("R5 two matches no flag", v, 0);
    run(4); rd(3, v); chk("R5 third match sets flag", v, 1);
    run(5); rd(3, v); chk("R6 flag sticky", v, 1);
    wr(3, 0); rd(3, v); chk("R6 flag cleared", v, 0);
    // R3 R4 period below count: wrap without match
    wr(2, 8'h01); wr(0, 8'hF0); wr(1, 8'h10);
    run(15); rd(0, v); chk("R3 run past period", v, 8'hFF);
    run(1); rd(0, v); chk("R3 wrap to zero", v, 0);
    rd(3, v); chk("R4 R5 wrap is not a match", v, 0);
    run(17); rd(3, v); chk("R5 later match sets flag", v, 1);
    // R6 hardware set wins over clear in same cycle
    wr(1, 0); wr(0, 0); wr(3, 0);
    rd(3, v); chk("R6 cleared before race", v, 0);
    run(1); rd(3, v); chk("R6 set by match", v, 1);
    @(negedge clk); bus_we = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h00; tick_en = 1'b1;
    @(negedge clk); bus_we = 1'b0; bus_addr = 2'd0; tick_en = 1'b0;
    rd(3, v); chk("R6 hardware set wins", v, 1);
    // mixed stream: prescale 1:4, postscale 1:4, period 2, irregular ticks
    wr(3, 0); wr(1, 2); wr(2, 8'h1B);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 2'(i % 4);
      tick_en = (i % 3) != 0;
      if (i == 150) begin bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h01; end
      if (i == 200) begin bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h19; end
    end
    @(negedge clk); bus_we = 1'b0; tick_en = 1'b0;
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule